// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Protection Checking

This block translates 32-bit virtual addresses into physical frame numbers for 8 KB pages. It holds two separate arrays of cached translations: one serves instruction fetches, the other serves data loads and stores. Each array is organised as 16 sets of 4 ways. A lookup indexes one set with the low bits of the page number and compares all four ways at once. A way matches when its page number is equal and the entry is either global or tagged with the caller's process ID.

On a match, a fixed-priority chain of protection checks runs. Each check is enabled by its own bit in a configuration word. The first check that fails gives a vector number: an exception base for the array in use plus a per-fault offset. If no check fails, the block grants read, write and execute rights.

Every fault outside debug mode loads two capture registers. The select register records the set and the way that a refill handler should overwrite. The cause register records the process ID, the kind of access and the faulting page. On a miss, the way comes from a free-running 16-bit replacement LFSR. A flush command invalidates, in one cycle, every private valid entry that belongs to a given process ID. Entries are loaded through a separate write port. The write port and a lookup must not address the same entry in the same cycle.

Top module: `pagemap_tlb`

## Requirements
- R1: The page number is address bits [31:13] and the set is page bits [3:0]. All four ways of that set are compared. Results appear one cycle after `lkValid`, with `rspValid` high. Reset clears `rspValid`, `rspHit`, `selReg` and `causeReg`.
- R2: An entry is built from `wrHi` and `wrLo`. `wrHi` carries the page in [31:13] and the process ID in [7:0]. A way matches on an equal page number when its global bit is set or its process ID equals `lkPid`. When several ways match, the lowest-numbered way is used.
- R3: `lkType` is 0 for fetch, 1 for load and 2 for store. A fetch searches only the instruction array (`wrData`=0) and has vector base 4. Loads and stores search only the data array (`wrData`=1) and have vector base 8.
- R4: `wrLo` flags are global at bit 4, valid at 3, kernel at 2, writable at 1 and executable at 0. `mmuCfg` enables are write-check at 19, kernel-check at 18, exec-check at 17 and valid-check at 16. On a match, the first failing check sets the vector, in this order: kernel-check with a kernel entry in user mode gives base+2; a store with write-check on a non-writable entry gives base+3; a fetch with exec-check on a non-executable entry gives base+3; valid-check on an invalid entry gives base+1. A miss gives base+0.
- R5: A clean hit raises `rspHit` and `rspRead`. `rspWrite` follows the entry's writable bit. `rspExec` is set only for instruction-array hits, and only when exec-check or the entry's executable bit is set. A clean hit reports the base vector. Any fault clears `rspHit` and all three rights.
- R6: On a non-debug fault, `selReg` takes the set in [3:0] and a way in [5:4]. The way is the matched way for a protection fault, or LFSR bits [1:0] for a miss. The LFSR starts at 0xCCCC. On every non-debug fault it shifts right by one, and its new bit 15 is the parity of old bits 15, 11, 2 and 0.
- R7: On a non-debug fault, `causeReg` takes the process ID in [7:0], an access code in [9:8] and the page number in [31:13]. The access code is 1 for fetch, 2 for store and 3 for load. Bits [12:10] keep their value. A clean hit leaves both capture registers unchanged.
- R8: A lookup with `lkDebug` high returns the normal response but changes neither capture register nor the LFSR.
- R9: `flushEn` clears the valid bit of every entry in both arrays that is valid, not global, and tagged with `flushPid`. All other entries are left unchanged.
- R10: `rspFrame` carries the matched way's frame number (`wrLo` bits [31:13]) whenever a way matched, including on protection faults. It is zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one entry |
| wrData | input | 1 | Target array: 0 instruction, 1 data |
| wrSet | input | 4 | Set to write |
| wrWay | input | 2 | Way to write |
| wrHi | input | 32 | Tag word: page number and process ID |
| wrLo | input | 32 | Frame word: frame number and flags |
| flushEn | input | 1 | Invalidate private entries of one process |
| flushPid | input | 8 | Process ID to flush |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address |
| lkType | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lkUser | input | 1 | Request comes from user mode |
| lkPid | input | 8 | Current process ID |
| lkDebug | input | 1 | Side-effect-free lookup |
| mmuCfg | input | 32 | Configuration word holding the check enables |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Translation succeeded |
| rspFrame | output | 19 | Physical frame number |
| rspRead | output | 1 | Read granted |
| rspWrite | output | 1 | Write granted |
| rspExec | output | 1 | Execute granted |
| rspVec | output | 4 | Exception vector number |
| selReg | output | 6 | Refill select register |
| causeReg | output | 32 | Fault cause register |

## Verification
Lookups are tried with the following patterns:
- an empty-set miss, which shows that the LFSR supplies the refill way;
- a matching and then a mismatching process ID against a private entry, which separates the two tag-compare paths;
- two global entries in one set, which shows that the lowest way wins whatever the ID;
- one entry that carries every fault, probed with check enables switched off one at a time, which exposes each level of the priority chain.

Fetches are sent to addresses that hold only data entries, and the reverse, to confirm that the two arrays are separate. Debug lookups are placed between normal faults, so a stray LFSR step would show up as a wrong way on the next miss. A flush is applied to a set that mixes matching private entries, matching global entries and entries of another ID, across both arrays.

// File: rtl/pagemap_pkg.sv
`timescale 1ns/1ps
package pagemap_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = ADDR_W - PAGE_SHIFT;
  localparam int PID_W      = 8;

  // Frame-word flag positions
  localparam int LO_GLB = 4;
  localparam int LO_VLD = 3;
  localparam int LO_KRN = 2;
  localparam int LO_WR  = 1;
  localparam int LO_EX  = 0;

  // Check-enable positions in the configuration word
  localparam int CFG_WCHK = 19;
  localparam int CFG_KCHK = 18;
  localparam int CFG_XCHK = 17;
  localparam int CFG_VCHK = 16;

  localparam int CAUSE_CODE_LSB = 8;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [1:0] CODE_EXEC  = 2'd1;
  localparam logic [1:0] CODE_WRITE = 2'd2;
  localparam logic [1:0] CODE_READ  = 2'd3;

  localparam logic [3:0] VBASE_INSTR = 4'd4;
  localparam logic [3:0] VBASE_DATA  = 4'd8;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic             glb;
    logic             vld;
    logic             krn;
    logic             wr;
    logic             ex;
  } entry_t;

  // Datapath -> control: what the compare found
  typedef struct packed {
    logic hit;
    logic vld;
    logic krn;
    logic wr;
    logic ex;
  } probe_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic       rspLoad;
    logic       capLoad;
    logic       wayFromRand;
    logic       okHit;
    logic [3:0] vec;
    logic       gWrite;
    logic       gExec;
    logic [1:0] accCode;
  } strobe_t;
endpackage

// File: rtl/pagemap_ctrl.sv
`timescale 1ns/1ps
module pagemap_ctrl
  import pagemap_pkg::*;
(
  input  logic       lkValid,
  input  logic [1:0] lkType,
  input  logic       lkUser,
  input  logic       lkDebug,
  input  logic [3:0] cfgChk,   // {write, kernel, exec, valid}
  input  probe_t     probe,
  output logic       isInstr,
  output strobe_t    strb
);
  logic isFetch;
  logic isStore;
  logic chkW, chkK, chkX, chkV;
  logic kFault, wFault, xFault, vFault;
  logic [3:0] vecBase;
  logic [1:0] vecOff;
  logic anyFault;

  assign chkW = cfgChk[3];
  assign chkK = cfgChk[2];
  assign chkX = cfgChk[1];
  assign chkV = cfgChk[0];

  assign isFetch = (lkType == ACC_FETCH);
  assign isStore = (lkType == ACC_STORE);
  assign isInstr = isFetch;

  // R3: array choice and vector base
  assign vecBase = isFetch ? VBASE_INSTR : VBASE_DATA;

  // R4: individual protection conditions
  assign kFault = chkK & probe.krn & lkUser;
  assign wFault = isStore & chkW & ~probe.wr;
  assign xFault = isFetch & chkX & ~probe.ex;
  assign vFault = chkV & ~probe.vld;

  // R4: fixed-priority selection of the offset
  always_comb begin
    vecOff   = 2'd0;
    anyFault = 1'b1;
    if (!probe.hit) begin
      vecOff = 2'd0;
    end else if (kFault) begin
      vecOff = 2'd2;
    end else if (wFault) begin
      vecOff = 2'd3;
    end else if (xFault) begin
      vecOff = 2'd3;
    end else if (vFault) begin
      vecOff = 2'd1;
    end else begin
      anyFault = 1'b0;
    end
  end

  always_comb begin
    strb             = '0;
    strb.rspLoad     = lkValid;
    strb.okHit       = ~anyFault;
    strb.capLoad     = lkValid & anyFault & ~lkDebug;
    strb.wayFromRand = ~probe.hit;
    strb.vec         = vecBase | {2'b00, vecOff};
    // R5: granted rights
    strb.gWrite      = ~anyFault & probe.wr;
    strb.gExec       = ~anyFault & isFetch & (chkX | probe.ex);
    // R7: access code
    if (isFetch)      strb.accCode = CODE_EXEC;
    else if (isStore) strb.accCode = CODE_WRITE;
    else              strb.accCode = CODE_READ;
  end
endmodule

// File: rtl/pagemap_dp.sv
`timescale 1ns/1ps
module pagemap_dp
  import pagemap_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEL_W = IDX_W + WAY_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  // entry write
  input  logic                 wrEn,
  input  logic                 wrData,
  input  logic [IDX_W-1:0]     wrSet,
  input  logic [WAY_W-1:0]     wrWay,
  input  entry_t               wrEnt,
  // flush
  input  logic                 flushEn,
  input  logic [PID_W-1:0]     flushPid,
  // lookup
  input  logic                 lkValid,
  input  logic [VPN_W-1:0]     lkVpn,
  input  logic [PID_W-1:0]     lkPid,
  input  logic                 isInstr,
  output probe_t               probe,
  input  strobe_t              strb,
  // registered results
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [VPN_W-1:0]     rspFrame,
  output logic                 rspRead,
  output logic                 rspWrite,
  output logic                 rspExec,
  output logic [3:0]           rspVec,
  output logic [SEL_W-1:0]     selReg,
  output logic [ADDR_W-1:0]    causeReg
);
  // index 0: instruction array, index 1: data array
  entry_t tbl [2][SETS][WAYS];

  logic [IDX_W-1:0] lkIdx;
  logic             arrSel;
  entry_t           wayEnt [WAYS];
  logic [WAYS-1:0]  wayHit;
  logic [WAY_W-1:0] hitWay;
  logic             anyHit;
  entry_t           hitEnt;
  logic [LFSR_W-1:0] lfsr;
  logic [WAY_W-1:0] capWay;

  assign lkIdx  = lkVpn[IDX_W-1:0];
  assign arrSel = ~isInstr;

  // R1, R2: parallel compare of every way in the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayEnt[w] = tbl[arrSel][lkIdx][w];
    assign wayHit[w] = (wayEnt[w].vpn == lkVpn) &&
                       (wayEnt[w].glb || (wayEnt[w].pid == lkPid));
  end

  // R2: lowest matching way wins
  always_comb begin
    hitWay = '0;
    anyHit = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) begin
        hitWay = WAY_W'(w);
        anyHit = 1'b1;
      end
    end
  end

  assign hitEnt    = wayEnt[hitWay];
  assign probe.hit = anyHit;
  assign probe.vld = hitEnt.vld;
  assign probe.krn = hitEnt.krn;
  assign probe.wr  = hitEnt.wr;
  assign probe.ex  = hitEnt.ex;

  // Entry storage: write port and per-process flush (R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            tbl[a][s][w] <= '0;
    end else begin
      if (flushEn) begin
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
              if (tbl[a][s][w].vld && !tbl[a][s][w].glb &&
                  (tbl[a][s][w].pid == flushPid))
                tbl[a][s][w].vld <= 1'b0;
      end
      if (wrEn) tbl[wrData][wrSet][wrWay] <= wrEnt;
    end
  end

  // R6: replacement LFSR, one step per recorded fault
  always_ff @(posedge clk) begin
    if (!rst_n)            lfsr <= LFSR_SEED;
    else if (strb.capLoad) lfsr <= {^(lfsr & LFSR_TAPS), lfsr[LFSR_W-1:1]};
  end

  assign capWay = strb.wayFromRand ? lfsr[WAY_W-1:0] : hitWay;

  // R6, R7, R8: capture registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg   <= '0;
      causeReg <= '0;
    end else if (strb.capLoad) begin
      selReg                                 <= {capWay, lkIdx};
      causeReg[PID_W-1:0]                    <= lkPid;
      causeReg[CAUSE_CODE_LSB +: 2]          <= strb.accCode;
      causeReg[ADDR_W-1:PAGE_SHIFT]          <= lkVpn;
    end
  end

  // R1, R5, R10: registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspFrame <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
      rspVec   <= '0;
    end else begin
      rspValid <= lkValid;
      if (strb.rspLoad) begin
        rspHit   <= strb.okHit;
        rspFrame <= anyHit ? hitEnt.pfn : '0;
        rspRead  <= strb.okHit;
        rspWrite <= strb.gWrite;
        rspExec  <= strb.gExec;
        rspVec   <= strb.vec;
      end
    end
  end
endmodule

// File: rtl/pagemap_tlb.sv
`timescale 1ns/1ps
module pagemap_tlb
  import pagemap_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEL_W = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic [IDX_W-1:0]  wrSet,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [31:0]       wrHi,
  input  logic [31:0]       wrLo,
  input  logic              flushEn,
  input  logic [7:0]        flushPid,
  input  logic              lkValid,
  input  logic [31:0]       lkAddr,
  input  logic [1:0]        lkType,
  input  logic              lkUser,
  input  logic [7:0]        lkPid,
  input  logic              lkDebug,
  input  logic [31:0]       mmuCfg,
  output logic              rspValid,
  output logic              rspHit,
  output logic [18:0]       rspFrame,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [3:0]        rspVec,
  output logic [SEL_W-1:0]  selReg,
  output logic [31:0]       causeReg
);
  entry_t  wrEnt;
  probe_t  probe;
  strobe_t strb;
  logic    isInstr;
  logic    unusedBits;

  assign wrEnt.vpn = wrHi[ADDR_W-1:PAGE_SHIFT];
  assign wrEnt.pid = wrHi[PID_W-1:0];
  assign wrEnt.pfn = wrLo[ADDR_W-1:PAGE_SHIFT];
  assign wrEnt.glb = wrLo[LO_GLB];
  assign wrEnt.vld = wrLo[LO_VLD];
  assign wrEnt.krn = wrLo[LO_KRN];
  assign wrEnt.wr  = wrLo[LO_WR];
  assign wrEnt.ex  = wrLo[LO_EX];

  assign unusedBits = ^{wrHi[PAGE_SHIFT-1:PID_W], wrLo[PAGE_SHIFT-1:LO_GLB+1],
                        lkAddr[PAGE_SHIFT-1:0], mmuCfg[31:CFG_WCHK+1],
                        mmuCfg[CFG_VCHK-1:0]};

  pagemap_ctrl u_ctrl (
    .lkValid (lkValid),
    .lkType  (lkType),
    .lkUser  (lkUser),
    .lkDebug (lkDebug),
    .cfgChk  (mmuCfg[CFG_WCHK:CFG_VCHK]),
    .probe   (probe),
    .isInstr (isInstr),
    .strb    (strb)
  );

  pagemap_dp #(.WAYS(WAYS), .SETS(SETS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .wrSet    (wrSet),
    .wrWay    (wrWay),
    .wrEnt    (wrEnt),
    .flushEn  (flushEn),
    .flushPid (flushPid),
    .lkValid  (lkValid),
    .lkVpn    (lkAddr[ADDR_W-1:PAGE_SHIFT]),
    .lkPid    (lkPid),
    .isInstr  (isInstr),
    .probe    (probe),
    .strb     (strb),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspFrame (rspFrame),
    .rspRead  (rspRead),
    .rspWrite (rspWrite),
    .rspExec  (rspExec),
    .rspVec   (rspVec),
    .selReg   (selReg),
    .causeReg (causeReg)
  );
endmodule

// File: rtl/pagemap_chk.sv
`timescale 1ns/1ps
module pagemap_chk #(
  parameter int IDX_W = 4,
  parameter int SEL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lkValid,
  input logic [31:0]      lkAddr,
  input logic [1:0]       lkType,
  input logic [7:0]       lkPid,
  input logic             lkDebug,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspRead,
  input logic             rspWrite,
  input logic             rspExec,
  input logic [3:0]       rspVec,
  input logic [SEL_W-1:0] selReg,
  input logic [31:0]      causeReg
);
  // R5
  hit_grants_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspHit) |-> rspRead);

  // R5
  fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspHit) |-> (!rspRead && !rspWrite && !rspExec));

  // R5
  data_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspVec[3]) |-> !rspExec);

  // R3
  fetch_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkType == 2'd0) |=> (rspVec[3:2] == 2'b01));

  // R8
  debug_keeps_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkDebug) |=> ($stable(causeReg) && $stable(selReg)));

  // R6
  sel_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && !lkDebug) |=> (rspHit || selReg[IDX_W-1:0] == $past(lkAddr[13 +: IDX_W])));

  // R7
  cause_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && !lkDebug) |=> (rspHit || causeReg[7:0] == $past(lkPid)));
endmodule

bind pagemap_tlb pagemap_chk #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lkValid  (lkValid),
  .lkAddr   (lkAddr),
  .lkType   (lkType),
  .lkPid    (lkPid),
  .lkDebug  (lkDebug),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspRead  (rspRead),
  .rspWrite (rspWrite),
  .rspExec  (rspExec),
  .rspVec   (rspVec),
  .selReg   (selReg),
  .causeReg (causeReg)
);

// File: tb/tb_pagemap_tlb.sv
`timescale 1ns/1ps
module tb_pagemap_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0, wrData = 1'b0;
  logic [3:0]  wrSet = '0;
  logic [1:0]  wrWay = '0;
  logic [31:0] wrHi = '0, wrLo = '0;
  logic        flushEn = 1'b0;
  logic [7:0]  flushPid = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic [1:0]  lkType = '0;
  logic        lkUser = 1'b0;
  logic [7:0]  lkPid = '0;
  logic        lkDebug = 1'b0;
  logic [31:0] mmuCfg = '0;
  logic        rspValid, rspHit, rspRead, rspWrite, rspExec;
  logic [18:0] rspFrame;
  logic [3:0]  rspVec;
  logic [5:0]  selReg;
  logic [31:0] causeReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] lfsrM = 16'hCCCC;
  logic [5:0]  expSel = '0;
  logic [31:0] expCause = '0;

  localparam logic [1:0] T_FETCH = 2'd0, T_LOAD = 2'd1, T_STORE = 2'd2;
  localparam logic [31:0] CFG_ALL = 32'h000F_0000;

  always #2.5 clk = ~clk;

  pagemap_tlb dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .wrSet(wrSet),
    .wrWay(wrWay), .wrHi(wrHi), .wrLo(wrLo), .flushEn(flushEn),
    .flushPid(flushPid), .lkValid(lkValid), .lkAddr(lkAddr), .lkType(lkType),
    .lkUser(lkUser), .lkPid(lkPid), .lkDebug(lkDebug), .mmuCfg(mmuCfg),
    .rspValid(rspValid), .rspHit(rspHit), .rspFrame(rspFrame),
    .rspRead(rspRead), .rspWrite(rspWrite), .rspExec(rspExec),
    .rspVec(rspVec), .selReg(selReg), .causeReg(causeReg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHi(input logic [18:0] vpn, input logic [7:0] pid);
    return {vpn, 5'b0, pid};
  endfunction

  function automatic logic [31:0] mkLo(input logic [18:0] pfn, input logic g, v, k, w, x);
    return {pfn, 8'b0, g, v, k, w, x};
  endfunction

  task automatic wrEntry(input logic arr, input logic [3:0] set, input logic [1:0] way,
                         input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wrEn = 1'b1; wrData = arr; wrSet = set; wrWay = way; wrHi = hi; wrLo = lo;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // One lookup, checking the response and both capture registers.
  task automatic runLook(input string req, input logic [18:0] vpn, input logic [1:0] typ,
                         input logic usr, input logic [7:0] pid, input logic dbg,
                         input logic [31:0] cfg, input logic eHit, input logic [3:0] eVec,
                         input logic [18:0] eFrame, input logic eW, input logic eX,
                         input int eWay);
    logic [1:0] code;
    logic [1:0] way;
    @(negedge clk);
    lkValid = 1'b1; lkAddr = {vpn, 13'h15A5}; lkType = typ; lkUser = usr;
    lkPid = pid; lkDebug = dbg; mmuCfg = cfg;
    @(posedge clk); #1;
    lkValid = 1'b0;
    code = (typ == T_FETCH) ? 2'd1 : (typ == T_STORE) ? 2'd2 : 2'd3;
    if (!eHit && !dbg) begin
      way = (eWay < 0) ? lfsrM[1:0] : 2'(eWay);
      expSel = {way, vpn[3:0]};
      expCause = {vpn, expCause[12:10], code, pid};
      lfsrM = {^(lfsrM & 16'h8805), lfsrM[15:1]};
    end
    chk({req, " R1 rspValid"}, 32'(rspValid), 32'd1);
    chk({req, " hit"}, 32'(rspHit), 32'(eHit));
    chk({req, " vector"}, 32'(rspVec), 32'(eVec));
    chk({req, " R10 frame"}, 32'(rspFrame), 32'(eFrame));
    chk({req, " R5 read"}, 32'(rspRead), 32'(eHit));
    chk({req, " R5 write"}, 32'(rspWrite), 32'(eW));
    chk({req, " R5 exec"}, 32'(rspExec), 32'(eX));
    chk({req, dbg ? " R8 sel" : " R6 sel"}, 32'(selReg), 32'(expSel));
    chk({req, dbg ? " R8 cause" : " R7 cause"}, causeReg, expCause);
  endtask

  task automatic testReset();
    chk("R1 reset rspValid", 32'(rspValid), 32'd0);
    chk("R1 reset rspHit", 32'(rspHit), 32'd0);
    chk("R1 reset selReg", 32'(selReg), 32'd0);
    chk("R1 reset causeReg", causeReg, 32'd0);
  endtask

  task automatic testMissAndHit();
    runLook("R1 empty miss", 19'h00123, T_LOAD, 1'b0, 8'h11, 1'b0, 32'h0,
            1'b0, 4'd8, 19'h0, 1'b0, 1'b0, -1);
    wrEntry(1'b1, 4'd3, 2'd2, mkHi(19'h00453, 8'h07), mkLo(19'h0ABCD, 0, 1, 0, 1, 0));
    runLook("R5 clean load", 19'h00453, T_LOAD, 1'b0, 8'h07, 1'b0, 32'h0,
            1'b1, 4'd8, 19'h0ABCD, 1'b1, 1'b0, 0);
    runLook("R5 clean store all checks", 19'h00453, T_STORE, 1'b0, 8'h07, 1'b0, CFG_ALL,
            1'b1, 4'd8, 19'h0ABCD, 1'b1, 1'b0, 0);
    runLook("R3 fetch uses instr array", 19'h00453, T_FETCH, 1'b0, 8'h07, 1'b0, 32'h0,
            1'b0, 4'd4, 19'h0, 1'b0, 1'b0, -1);
  endtask

  task automatic testMatchRule();
    runLook("R2 pid mismatch", 19'h00453, T_LOAD, 1'b0, 8'h09, 1'b0, 32'h0,
            1'b0, 4'd8, 19'h0, 1'b0, 1'b0, -1);
    wrEntry(1'b1, 4'd5, 2'd1, mkHi(19'h07775, 8'h33), mkLo(19'h00111, 1, 1, 0, 0, 0));
    wrEntry(1'b1, 4'd5, 2'd3, mkHi(19'h07775, 8'h44), mkLo(19'h00333, 1, 1, 0, 1, 0));
    runLook("R2 global any pid", 19'h07775, T_LOAD, 1'b0, 8'h55, 1'b0, 32'h0,
            1'b1, 4'd8, 19'h00111, 1'b0, 1'b0, 0);
    runLook("R2 lowest way wins", 19'h07775, T_LOAD, 1'b0, 8'h44, 1'b0, 32'h0,
            1'b1, 4'd8, 19'h00111, 1'b0, 1'b0, 0);
  endtask

  task automatic testPriority();
    wrEntry(1'b1, 4'd6, 2'd1, mkHi(19'h01236, 8'h21), mkLo(19'h00222, 0, 0, 1, 0, 0));
    runLook("R4 kernel fault", 19'h01236, T_STORE, 1'b1, 8'h21, 1'b0, CFG_ALL,
            1'b0, 4'd10, 19'h00222, 1'b0, 1'b0, 1);
    runLook("R4 write fault", 19'h01236, T_STORE, 1'b0, 8'h21, 1'b0, CFG_ALL,
            1'b0, 4'd11, 19'h00222, 1'b0, 1'b0, 1);
    runLook("R4 invalid fault", 19'h01236, T_LOAD, 1'b0, 8'h21, 1'b0, CFG_ALL,
            1'b0, 4'd9, 19'h00222, 1'b0, 1'b0, 1);
    runLook("R4 valid check off", 19'h01236, T_LOAD, 1'b0, 8'h21, 1'b0, 32'h000E_0000,
            1'b1, 4'd8, 19'h00222, 1'b0, 1'b0, 0);
    runLook("R4 kernel check off", 19'h01236, T_LOAD, 1'b1, 8'h21, 1'b0, 32'h0003_0000,
            1'b0, 4'd9, 19'h00222, 1'b0, 1'b0, 1);
    wrEntry(1'b0, 4'd9, 2'd3, mkHi(19'h02229, 8'h21), mkLo(19'h00444, 0, 0, 0, 1, 0));
    runLook("R4 exec fault", 19'h02229, T_FETCH, 1'b0, 8'h21, 1'b0, CFG_ALL,
            1'b0, 4'd7, 19'h00444, 1'b0, 1'b0, 3);
    runLook("R4 instr invalid", 19'h02229, T_FETCH, 1'b0, 8'h21, 1'b0, 32'h0001_0000,
            1'b0, 4'd5, 19'h00444, 1'b0, 1'b0, 3);
    runLook("R5 fetch no exec", 19'h02229, T_FETCH, 1'b0, 8'h21, 1'b0, 32'h0,
            1'b1, 4'd4, 19'h00444, 1'b1, 1'b0, 0);
    wrEntry(1'b0, 4'd9, 2'd3, mkHi(19'h02229, 8'h21), mkLo(19'h00444, 0, 1, 0, 1, 1));
    runLook("R5 fetch exec", 19'h02229, T_FETCH, 1'b0, 8'h21, 1'b0, 32'h0002_0000,
            1'b1, 4'd4, 19'h00444, 1'b1, 1'b1, 0);
    wrEntry(1'b1, 4'd6, 2'd2, mkHi(19'h03336, 8'h21), mkLo(19'h00555, 0, 1, 0, 0, 1));
    runLook("R5 data never exec", 19'h03336, T_LOAD, 1'b0, 8'h21, 1'b0, 32'h0002_0000,
            1'b1, 4'd8, 19'h00555, 1'b0, 1'b0, 0);
  endtask

  task automatic testDebug();
    runLook("R8 debug miss", 19'h00453, T_LOAD, 1'b0, 8'h99, 1'b1, 32'h0,
            1'b0, 4'd8, 19'h0, 1'b0, 1'b0, -1);
    runLook("R8 debug protect", 19'h01236, T_STORE, 1'b1, 8'h21, 1'b1, CFG_ALL,
            1'b0, 4'd10, 19'h00222, 1'b0, 1'b0, 1);
    runLook("R6 lfsr after debug", 19'h0000A, T_LOAD, 1'b0, 8'h12, 1'b0, 32'h0,
            1'b0, 4'd8, 19'h0, 1'b0, 1'b0, -1);
    runLook("R6 lfsr next miss", 19'h0000B, T_STORE, 1'b0, 8'h12, 1'b0, 32'h0,
            1'b0, 4'd8, 19'h0, 1'b0, 1'b0, -1);
  endtask

  task automatic testFlush();
    wrEntry(1'b1, 4'd12, 2'd0, mkHi(19'h0444C, 8'h50), mkLo(19'h00601, 0, 1, 0, 1, 0));
    wrEntry(1'b1, 4'd12, 2'd1, mkHi(19'h0555C, 8'h50), mkLo(19'h00602, 1, 1, 0, 1, 0));
    wrEntry(1'b1, 4'd12, 2'd2, mkHi(19'h0666C, 8'h51), mkLo(19'h00603, 0, 1, 0, 1, 0));
    wrEntry(1'b0, 4'd12, 2'd0, mkHi(19'h0444C, 8'h50), mkLo(19'h00604, 0, 1, 0, 0, 1));
    @(negedge clk);
    flushEn = 1'b1; flushPid = 8'h50;
    @(posedge clk); #1;
    flushEn = 1'b0;
    runLook("R9 private flushed", 19'h0444C, T_LOAD, 1'b0, 8'h50, 1'b0, 32'h0001_0000,
            1'b0, 4'd9, 19'h00601, 1'b0, 1'b0, 0);
    runLook("R9 global kept", 19'h0555C, T_LOAD, 1'b0, 8'h50, 1'b0, 32'h0001_0000,
            1'b1, 4'd8, 19'h00602, 1'b1, 1'b0, 0);
    runLook("R9 other pid kept", 19'h0666C, T_LOAD, 1'b0, 8'h51, 1'b0, 32'h0001_0000,
            1'b1, 4'd8, 19'h00603, 1'b1, 1'b0, 0);
    runLook("R9 instr array flushed", 19'h0444C, T_FETCH, 1'b0, 8'h50, 1'b0, 32'h0001_0000,
            1'b0, 4'd5, 19'h00604, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rst_n = 1'b1;
    testMissAndHit();
    testMatchRule();
    testPriority();
    testDebug();
    testFlush();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule